// File: doc/BRIEF.md
# Self-Routing Omega Network

This block is an N x N multistage switching fabric. It is built from log2(N) columns of 2x2 switching cells, and a perfect-shuffle wiring sits in front of every column. Each source port presents a valid flag, a destination tag and a payload. Every cell picks straight or crossed from one tag bit of the packets it sees, so no central controller is needed. The tag's most significant bit steers the first column and its least significant bit steers the last. A packet with no conflict on its path reaches the output port whose index equals its tag, in the same cycle.

Two packets may meet in one cell and ask for the same cell output. In that case a one-bit round-robin pointer in that cell chooses the winner. The losing packet is dropped at that point, and a blocked flag is raised to its source port. The fabric has no buffering and no retry. The source decides what to do with a blocked packet.

The data path is purely combinational. The only state is the set of round-robin pointers, one per cell. A pointer flips on the clock edge that ends a cycle in which its cell settled a conflict.

Top module: `omega_net`

## Requirements
- R1: While reset is held, every pointer is cleared, so the first conflict at any cell after reset is won by the packet on that cell's upper input. In stage 0, cell k has source k on its upper input and source k+N/2 on its lower input.
- R2: A packet whose path has no conflict appears at `out_valid[tag]` with its payload on `out_data[tag*W +: W]` in the same cycle. Its blocked flag stays low.
- R3: Tag bits are consumed most significant bit first. A tag bit of 0 takes the upper cell output and a bit of 1 takes the lower one. As a result, sources 0 and N/2 collide at stage 0 when their tags share the top bit, and they do not collide there when the top bits differ.
- R4: When two valid packets in one cell ask for the same output, exactly one passes. The loser's source gets `in_blocked` high, and the loser drives no output.
- R5: After every cycle in which a cell settled a conflict, that cell's pointer flips, so repeated conflicts at the same cell alternate winners.
- R6: Idle inputs (valid low) never win, are never reported blocked, and never change a pointer. This includes cycles in which a cell carries only one packet or two packets headed to different outputs.
- R7: An output with no packet has `out_valid` low and `out_data` all zero.
- R8: In every cycle, the count of raised `out_valid` bits plus the count of raised `in_blocked` bits equals the count of valid inputs. If any input is valid, at least one output is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the round-robin pointers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-source packet present |
| in_tag | input | N*log2(N) | Destination tags, source i at bits [i*log2(N) +: log2(N)] |
| in_data | input | N*W | Payloads, source i at bits [i*W +: W] |
| out_valid | output | N | Per-destination packet delivered |
| out_data | output | N*W | Delivered payloads, destination d at bits [d*W +: W] |
| in_blocked | output | N | Per-source flag: packet lost a conflict and was dropped |

## Verification
Delivery of a winner and blocking of a loser happen in the same cycle. When the cell settles that conflict, it also schedules a pointer flip for the next edge. The bench drives colliding packets through stage-0 and last-stage cells. In each case it checks three things together: the winner's payload at its destination, the loser's blocked flag, and the conservation of packet counts. It then repeats the same collision over consecutive cycles, with idle and conflict-free cycles in between, and checks that the winner alternates only when real conflicts occurred.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int LG = $clog2(N),
  localparam int SW = N / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N*LG-1:0] in_tag,
  input  logic [N*W-1:0]  in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*W-1:0]  out_data,
  output logic [N-1:0]    in_blocked
);

  function automatic int rotr(input int q);
    return (q >> 1) | ((q & 1) << (LG - 1));
  endfunction

  logic [LG:0][N-1:0]      sv;
  logic [LG-1:0]           st [LG+1][N];
  logic [W-1:0]            sd [LG+1][N];
  logic [LG-1:0]           ss [LG+1][N];
  logic [LG-1:0][SW-1:0]   rr;
  logic [LG-1:0][SW-1:0]   cont;
  logic [N-1:0]            delivered;

  always_comb begin
    int ua, la;
    logic ub, lbit, uw, lw, clash;
    ua = 0; la = 0; ub = 1'b0; lbit = 1'b0; uw = 1'b0; lw = 1'b0; clash = 1'b0;
    cont = '0;
    delivered = '0;
    for (int p = 0; p < N; p++) begin
      sv[0][p] = in_valid[p];
      st[0][p] = in_tag[p*LG +: LG];
      sd[0][p] = in_data[p*W +: W];
      ss[0][p] = LG'(p);
    end
    for (int s = 0; s < LG; s++) begin
      for (int p = 0; p < N; p++) begin
        sv[s+1][p] = 1'b0;
        st[s+1][p] = '0;
        sd[s+1][p] = '0;
        ss[s+1][p] = '0;
      end
      for (int k = 0; k < SW; k++) begin
        ua    = rotr(2*k);
        la    = rotr(2*k + 1);
        ub    = st[s][ua][LG-1-s];
        lbit  = st[s][la][LG-1-s];
        clash = sv[s][ua] & sv[s][la] & (ub == lbit);
        cont[s][k] = clash;
        uw = sv[s][ua] & (~clash | ~rr[s][k]);
        lw = sv[s][la] & (~clash |  rr[s][k]);
        if (uw) begin
          sv[s+1][2*k + int'(ub)] = 1'b1;
          st[s+1][2*k + int'(ub)] = st[s][ua];
          sd[s+1][2*k + int'(ub)] = sd[s][ua];
          ss[s+1][2*k + int'(ub)] = ss[s][ua];
        end
        if (lw) begin
          sv[s+1][2*k + int'(lbit)] = 1'b1;
          st[s+1][2*k + int'(lbit)] = st[s][la];
          sd[s+1][2*k + int'(lbit)] = sd[s][la];
          ss[s+1][2*k + int'(lbit)] = ss[s][la];
        end
      end
    end
    for (int p = 0; p < N; p++) begin
      out_data[p*W +: W] = sd[LG][p];
      if (sv[LG][p]) delivered[ss[LG][p]] = 1'b1;
    end
  end

  assign out_valid  = sv[LG];
  assign in_blocked = in_valid & ~delivered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr <= '0;
    else        rr <= rr ^ cont;
  end

  // R8
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) + $countones(in_blocked) == $countones(in_valid));

  // R8
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid != '0) |-> (out_valid != '0));

  // R6
  idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blocked & ~in_valid) == '0);

  // R6
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) < 2) |=> $stable(rr));

  // R4
  solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) == 1) |-> (in_blocked == '0 && $countones(out_valid) == 1));

endmodule

// File: tb/sim_omega_net.sv
module sim_omega_net;
  localparam int N = 8;
  localparam int W = 16;
  localparam int LG = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*LG-1:0] in_tag = '0;
  logic [N*W-1:0]  in_data;
  logic [N-1:0]    out_valid;
  logic [N*W-1:0]  out_data;
  logic [N-1:0]    in_blocked;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  omega_net #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .in_blocked(in_blocked));

  function automatic logic [W-1:0] pay(input int i);
    return 16'h5A00 ^ (16'(i) * 16'h0101);
  endfunction

  always_comb
    for (int i = 0; i < N; i++) in_data[i*W +: W] = pay(i);

  // {valid, tags, expected out_valid, expected in_blocked}; pointers fresh from reset
  localparam logic [47:0] VEC [8] = '{
    {8'hFF, 24'hFAC688, 8'hFF, 8'h00},  // identity, R2
    {8'hFF, 24'h000000, 8'h01, 8'hFE},  // all to 0, R4 R1
    {8'hFF, 24'h053977, 8'hFF, 8'h00},  // reversal, R2
    {8'h11, 24'h001000, 8'h01, 8'h10},  // top bits equal, R3
    {8'h11, 24'h004000, 8'h11, 8'h00},  // top bits differ, R3
    {8'h00, 24'h000000, 8'h00, 8'h00},  // idle, R7
    {8'h20, 24'h018000, 8'h08, 8'h00},  // single, R2
    {8'h06, 24'h0001B0, 8'h40, 8'h02}   // last-stage clash, R4
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] v, input logic [23:0] t,
                      input logic [7:0] ev, input logic [7:0] eb, input string req);
    logic [127:0] ed;
    in_valid = v;
    in_tag = t;
    #2;
    ed = '0;
    for (int d = 0; d < N; d++)
      if (ev[d])
        for (int i = 0; i < N; i++)
          if (v[i] && t[i*LG +: LG] == LG'(d) && !eb[i]) ed[d*W +: W] = pay(i);
    chk({req, " out_valid"}, 128'(out_valid), 128'(ev));
    chk({req, " in_blocked"}, 128'(in_blocked), 128'(eb));
    chk({req, " out_data"}, out_data, ed);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset out_valid", 128'(out_valid), 128'h0);
    chk("R1 reset in_blocked", 128'(in_blocked), 128'h0);
    for (int v = 0; v < 8; v++) begin
      rst_n = 1'b0;
      #1 rst_n = 1'b1;
      step(VEC[v][47:40], VEC[v][39:16], VEC[v][15:8], VEC[v][7:0], "R2/R3/R4/R7 table");
    end

    rst_n = 1'b0;
    #1 rst_n = 1'b1;
    step(8'h11, 24'h001000, 8'h01, 8'h10, "R1 first contest upper");
    step(8'h11, 24'h001000, 8'h02, 8'h01, "R5 second contest lower");
    step(8'h11, 24'h001000, 8'h01, 8'h10, "R5 third contest upper");
    step(8'h00, 24'h000000, 8'h00, 8'h00, "R6 idle");
    step(8'h00, 24'h001000, 8'h00, 8'h00, "R6 idle with tags");
    step(8'h01, 24'h000000, 8'h01, 8'h00, "R6 single packet");
    step(8'h11, 24'h004000, 8'h11, 8'h00, "R6 no clash");
    step(8'h11, 24'h001000, 8'h02, 8'h01, "R6 pointer kept");
    step(8'h06, 24'h0001B0, 8'h40, 8'h02, "R5 other cell untouched");
    step(8'h06, 24'h0001B0, 8'h40, 8'h04, "R5 last-stage alternates");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule